// File: doc/BRIEF.md
# Double-Buffered Serial Port

This block is a byte-wide asynchronous serial port placed on a 32-bit register bus. A data register and a status register are visible to software. On the send side, a holding register sits in front of a shift register, so a second byte can be queued while the first is still on the line. When a frame finishes, a queued byte starts its own frame at once, with no idle gap. On the receive side, one byte register holds the last accepted byte.

Each frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. The bit period is a fixed number of clock cycles, set by the `CLKS_PER_BIT` parameter. The status register shows whether the shift register is empty and whether the holding register is empty, as two separate flags. It also shows a data-ready flag and a sticky overrun flag, which is set when a byte arrives before the previous one was read.

A one-cycle interrupt strobe marks every finished transmit frame and every accepted received byte. The strobe is meant for the interrupt line of priority level 3.

Top module: `dbuf_uart`

## Requirements
- R1: After reset, the status register reads 0x00000006 (both transmit registers empty, no data ready, no overrun), the serial output is high and the interrupt strobe is low.
- R2: The data register is at offset 0x70 and returns the received byte in bits 7:0, with zeros above. The status register is at offset 0x74 and its bits are: bit 0 data ready, bit 1 shift register empty, bit 2 holding register empty, bit 4 overrun. All its other bits read 0. A read of any other offset returns 0.
- R3: The serial output idles high. A frame is one low start bit, eight data bits least significant bit first, and one high stop bit, and each bit lasts `CLKS_PER_BIT` cycles. A write to the data register while the shift register is empty drives the start bit from the clock edge that accepts the write.
- R4: A data write while the shift register is empty loads the shift register and clears bit 1, while bit 2 stays 1. A data write while the shift register is busy stores the byte in the holding register and clears bit 2.
- R5: When a frame ends and the holding register is full, the held byte starts the next frame with no idle gap and bit 2 becomes 1. When a frame ends and the holding register is empty, bit 1 becomes 1.
- R6: A received frame with a high stop bit stores its byte in the data register and sets bit 0. A frame whose stop bit is low is discarded. A low pulse shorter than half a bit is ignored. A new frame begins only on a high-to-low transition of the input.
- R7: A byte accepted while bit 0 is still set also sets bit 4. Bit 4 then stays set until a status write.
- R8: A read of the data register clears bit 0. A write to the status register clears bit 4 and leaves bit 0 unchanged.
- R9: The interrupt strobe is high for one cycle after each finished transmit frame and after each accepted received byte. A discarded frame gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| ser_txd | output | 1 | Serial output |
| ser_rxd | input | 1 | Serial input, asynchronous |
| irq_pulse | output | 1 | One-cycle interrupt strobe |

## Verification
The bench builds the block with `CLKS_PER_BIT` = 8, so a frame is 80 cycles long. This lets the bench send dozens of frames, back-to-back frames through the holding register, and overruns within the cycle budget. Because 8 is even, the half-bit start check falls on an exact cycle. A 2-cycle glitch and a frame with a low stop bit can therefore be placed unambiguously on each side of the accept rules. With the serial output looped back to the input, the random part runs every byte through both the transmitter and the receiver.

// File: rtl/dbuf_uart_pkg.sv
package dbuf_uart_pkg;

    localparam logic [7:0] DATA_OFS = 8'h70;
    localparam logic [7:0] STAT_OFS = 8'h74;

    localparam int ST_DR  = 0;
    localparam int ST_SRE = 1;
    localparam int ST_HRE = 2;
    localparam int ST_OVR = 4;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;

    typedef struct packed {
        logic ovr;
        logic hre;
        logic sre;
        logic dr;
    } uart_status_t;

    function automatic logic [31:0] pack_status(input uart_status_t s);
        logic [31:0] r;
        r         = '0;
        r[ST_DR]  = s.dr;
        r[ST_SRE] = s.sre;
        r[ST_HRE] = s.hre;
        r[ST_OVR] = s.ovr;
        return r;
    endfunction

endpackage

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       busy,
    output logic       done,
    output logic       txd
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

    line_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          txd_q;
    logic          bit_end;

    assign bit_end = (cnt_q == LAST);
    assign busy    = (state_q != LN_IDLE);
    assign done    = (state_q == LN_STOP) && bit_end;
    assign txd     = txd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LN_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            txd_q   <= 1'b1;
        end else if (load && (!busy || done)) begin
            state_q <= LN_START;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= load_byte;
            txd_q   <= 1'b0;
        end else if (busy) begin
            if (bit_end) begin
                cnt_q <= '0;
                case (state_q)
                    LN_START: begin
                        state_q <= LN_DATA;
                        txd_q   <= sh_q[0];
                    end
                    LN_DATA: begin
                        if (bit_q == 3'd7) begin
                            state_q <= LN_STOP;
                            txd_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {1'b0, sh_q[7:1]};
                            txd_q <= sh_q[1];
                        end
                    end
                    default: begin
                        state_q <= LN_IDLE;
                        txd_q   <= 1'b1;
                    end
                endcase
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dbuf_uart_rx.sv
module dbuf_uart_rx
    import dbuf_uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] rx_byte
);
    localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int HALF = (CLKS_PER_BIT / 2 > 0) ? CLKS_PER_BIT / 2 : 1;
    localparam logic [CW-1:0] LAST  = CW'(CLKS_PER_BIT - 1);
    localparam logic [CW-1:0] MID   = CW'(HALF - 1);

    logic [2:0]    sync_q;
    line_state_e   state_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          valid_q;
    logic          line;
    logic          fall;
    logic          bit_end;

    assign line    = sync_q[1];
    assign fall    = sync_q[2] && !sync_q[1];
    assign bit_end = (cnt_q == LAST);
    assign valid   = valid_q;
    assign rx_byte = sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 3'b111;
            state_q <= LN_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            sh_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            sync_q  <= {sync_q[1:0], rxd};
            valid_q <= 1'b0;
            case (state_q)
                LN_IDLE: begin
                    cnt_q <= '0;
                    if (fall) state_q <= LN_START;
                end
                LN_START: begin
                    if (cnt_q == MID) begin
                        cnt_q   <= '0;
                        bit_q   <= '0;
                        state_q <= line ? LN_IDLE : LN_DATA;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                LN_DATA: begin
                    if (bit_end) begin
                        cnt_q <= '0;
                        sh_q  <= {line, sh_q[7:1]};
                        if (bit_q == 3'd7) state_q <= LN_STOP;
                        else               bit_q   <= bit_q + 3'd1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (bit_end) begin
                        cnt_q   <= '0;
                        state_q <= LN_IDLE;
                        valid_q <= line;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/dbuf_uart.sv
module dbuf_uart
    import dbuf_uart_pkg::*;
#(
    parameter int CLKS_PER_BIT = 16,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ser_txd,
    input  logic              ser_rxd,
    output logic              irq_pulse
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic         rd_data, wr_data, wr_stat;
    logic         tx_busy, tx_done, tx_load, tx_free;
    logic [7:0]   tx_byte;
    logic         rx_valid;
    logic [7:0]   rx_byte;
    logic [7:0]   hold_q;
    logic         hold_full_q;
    logic [7:0]   rx_data_q;
    logic         dr_q, ovr_q, irq_q;
    logic         sre, hre;
    uart_status_t stat;
    logic         unused_wbits;

    assign unused_wbits = ^bus_wdata[31:8];

    assign rd_data = bus_sel && !bus_wr && (bus_addr == DATA_A);
    assign wr_data = bus_sel &&  bus_wr && (bus_addr == DATA_A);
    assign wr_stat = bus_sel &&  bus_wr && (bus_addr == STAT_A);

    assign tx_free = !tx_busy || tx_done;
    assign sre     = !tx_busy;
    assign hre     = !hold_full_q;

    always_comb begin
        tx_load = 1'b0;
        tx_byte = hold_q;
        if (tx_done && hold_full_q) begin
            tx_load = 1'b1;
        end else if (wr_data && tx_free) begin
            tx_load = 1'b1;
            tx_byte = bus_wdata[7:0];
        end
    end

    dbuf_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_byte (tx_byte),
        .busy      (tx_busy),
        .done      (tx_done),
        .txd       (ser_txd)
    );

    dbuf_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
        .clk     (clk),
        .rst     (rst),
        .rxd     (ser_rxd),
        .valid   (rx_valid),
        .rx_byte (rx_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (tx_done && hold_full_q) begin
            hold_full_q <= wr_data;
            if (wr_data) hold_q <= bus_wdata[7:0];
        end else if (wr_data && !tx_free) begin
            hold_q      <= bus_wdata[7:0];
            hold_full_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data_q <= '0;
            dr_q      <= 1'b0;
            ovr_q     <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (rx_valid) rx_data_q <= rx_byte;
            dr_q  <= rx_valid || (dr_q && !rd_data);
            ovr_q <= (ovr_q && !wr_stat) || (rx_valid && dr_q && !rd_data);
            irq_q <= tx_done || rx_valid;
        end
    end

    assign irq_pulse = irq_q;

    always_comb begin
        stat.dr   = dr_q;
        stat.sre  = sre;
        stat.hre  = hre;
        stat.ovr  = ovr_q;
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == DATA_A)      bus_rdata = {24'd0, rx_data_q};
            else if (bus_addr == STAT_A) bus_rdata = pack_status(stat);
        end
    end
endmodule

// File: rtl/dbuf_uart_chk.sv
module dbuf_uart_chk (
    input logic clk,
    input logic rst,
    input logic txd,
    input logic sre,
    input logic hre,
    input logic dr,
    input logic ovr,
    input logic rd_data,
    input logic wr_stat,
    input logic rx_valid
);
    // R3
    txd_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        sre |-> txd);

    // R4
    hold_needs_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !hre |-> !sre);

    // R8
    dr_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !rx_valid) |=> !dr);

    // R7
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && dr && !rd_data) |=> ovr);

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !wr_stat) |=> ovr);

    // R8
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !(rx_valid && dr && !rd_data)) |=> !ovr);

    // R6
    dr_source_chk: assert property (@(posedge clk) disable iff (rst)
        (!dr && !rx_valid) |=> !dr);
endmodule

bind dbuf_uart dbuf_uart_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .txd      (ser_txd),
    .sre      (sre),
    .hre      (hre),
    .dr       (dr_q),
    .ovr      (ovr_q),
    .rd_data  (rd_data),
    .wr_stat  (wr_stat),
    .rx_valid (rx_valid)
);

// File: tb/dbuf_uart_tb_top.sv
module dbuf_uart_tb_top;
    localparam int CPB = 8;
    localparam logic [7:0] A_DATA = 8'h70;
    localparam logic [7:0] A_STAT = 8'h74;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_txd;
    logic        ser_rxd;
    logic        irq_pulse;
    logic        rx_drv = 1'b1;
    logic        loop_en = 1'b0;

    int errors = 0;
    int checks = 0;
    int irq_cnt = 0;
    logic [7:0] tx_seen[$];
    logic [7:0] tx_exp[$];

    always #4 clk = ~clk;

    assign ser_rxd = loop_en ? ser_txd : rx_drv;

    dbuf_uart #(.CLKS_PER_BIT(CPB), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_txd(ser_txd), .ser_rxd(ser_rxd), .irq_pulse(irq_pulse)
    );

    always @(posedge clk) if (!rst && irq_pulse) irq_cnt <= irq_cnt + 1;

    // serial output decoder, samples mid-bit
    initial begin
        forever begin
            logic [7:0] b;
            @(negedge ser_txd);
            if (!rst) begin
                repeat (CPB / 2) @(posedge clk);
                #1;
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(posedge clk);
                    #1;
                    b[i] = ser_txd;
                end
                repeat (CPB) @(posedge clk);
                #1;
                if (ser_txd) tx_seen.push_back(b);
                else tx_seen.push_back(8'hxx);
            end
        end
    end

    function automatic logic [31:0] exp_stat(input bit dr, input bit sre, input bit hre, input bit ovr);
        return {27'd0, ovr, 1'b0, hre, sre, dr};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        if (a == A_DATA) tx_exp.push_back(d[7:0]);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit stop_ok);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_drv = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx_drv = stop_ok;
        repeat (CPB) @(negedge clk);
        rx_drv = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int i0;
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        bus_read(A_STAT, d);
        check(d == 32'h6, "R1 status after reset", d, 32'h6);
        check(ser_txd == 1'b1 && irq_pulse == 1'b0, "R1 txd/irq after reset", {30'd0, ser_txd, irq_pulse}, 32'h2);

        // R2 unmapped offset reads zero
        bus_read(8'h78, d);
        check(d == 0, "R2 unmapped read", d, 0);

        // R3 R4 first write starts frame, second queues
        i0 = irq_cnt;
        bus_write(A_DATA, 32'hFFFF_FFA5);
        check(ser_txd == 1'b0, "R3 start bit after write", {31'd0, ser_txd}, 0);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 0, 1, 0), "R4 shift loaded", d, exp_stat(0, 0, 1, 0));
        bus_write(A_DATA, 32'h3C);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 0, 0, 0), "R4 holding loaded", d, exp_stat(0, 0, 0, 0));

        // R5 after first frame, held byte on the line
        repeat (10 * CPB) @(negedge clk);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 0, 1, 0), "R5 hold moved to shift", d, exp_stat(0, 0, 1, 0));
        check(irq_cnt - i0 == 1, "R9 one strobe per frame", irq_cnt - i0, 1);
        repeat (10 * CPB) @(negedge clk);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 1, 1, 0), "R5 both empty at end", d, exp_stat(0, 1, 1, 0));
        check(irq_cnt - i0 == 2, "R9 strobes after two frames", irq_cnt - i0, 2);
        check(tx_seen.size() == 2, "R5 back-to-back frames seen", tx_seen.size(), 2);

        // R6 R8 directed receive
        i0 = irq_cnt;
        send_rx(8'h5A, 1'b1);
        bus_read(A_STAT, d);
        check(d == exp_stat(1, 1, 1, 0), "R6 data ready set", d, exp_stat(1, 1, 1, 0));
        check(irq_cnt - i0 == 1, "R9 strobe on receive", irq_cnt - i0, 1);
        bus_read(A_DATA, d);
        check(d == 32'h5A, "R2 data register value", d, 32'h5A);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 1, 1, 0), "R8 read clears ready", d, exp_stat(0, 1, 1, 0));

        // R6 low stop bit discarded, R9 no strobe
        i0 = irq_cnt;
        send_rx(8'h81, 1'b0);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 1, 1, 0), "R6 bad stop discarded", d, exp_stat(0, 1, 1, 0));
        check(irq_cnt == i0, "R9 no strobe on discard", irq_cnt - i0, 0);

        // R6 short glitch ignored
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (2) @(negedge clk);
        rx_drv = 1'b1;
        repeat (12 * CPB) @(negedge clk);
        bus_read(A_STAT, d);
        check(d == exp_stat(0, 1, 1, 0), "R6 glitch ignored", d, exp_stat(0, 1, 1, 0));
        check(irq_cnt == i0, "R6 glitch gives no strobe", irq_cnt - i0, 0);

        // R7 R8 overrun
        send_rx(8'h11, 1'b1);
        send_rx(8'h22, 1'b1);
        bus_read(A_STAT, d);
        check(d == exp_stat(1, 1, 1, 1), "R7 overrun set", d, exp_stat(1, 1, 1, 1));
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, d);
        check(d == exp_stat(1, 1, 1, 0), "R8 status write clears overrun only", d, exp_stat(1, 1, 1, 0));
        bus_read(A_DATA, d);
        check(d == 32'h22, "R7 newest byte kept", d, 32'h22);

        // random loopback
        loop_en = 1'b1;
        for (int n = 0; n < 24; n++) begin
            logic [7:0] b1, b2;
            bit two;
            b1 = 8'($urandom);
            b2 = 8'($urandom);
            two = ($urandom % 3) == 0;
            bus_write(A_DATA, {24'd0, b1});
            if (two) bus_write(A_DATA, {24'd0, b2});
            repeat ((two ? 22 : 12) * CPB) @(negedge clk);
            bus_read(A_STAT, d);
            check(d == exp_stat(1, 1, 1, two), "R7 loopback status", d, exp_stat(1, 1, 1, two));
            bus_read(A_DATA, d);
            check(d == {24'd0, two ? b2 : b1}, "R6 loopback byte", d, {24'd0, two ? b2 : b1});
            if (two) bus_write(A_STAT, 0);
        end
        loop_en = 1'b0;

        // R3 every transmitted frame decodes to the written byte
        check(tx_seen.size() == tx_exp.size(), "R3 frame count", tx_seen.size(), tx_exp.size());
        for (int k = 0; k < tx_exp.size() && k < tx_seen.size(); k++)
            check(tx_seen[k] === tx_exp[k], "R3 frame content", {24'd0, tx_seen[k]}, {24'd0, tx_exp[k]});

        finish_run();
    end
endmodule